// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Sequencer

This block sits between a clocked host and a 16-bit asynchronous static RAM. The memory has a pair of chip selects of opposite polarity, a write strobe, an output enable and one enable for each byte. The host raises a request with an address, a 16-bit write word, a two-bit lane mask and a direction flag. It holds the request until the block returns a one-clock acknowledge. For reads, the returned word is valid in the acknowledge cycle.

A write is opened with the chip selects, the address and the chosen byte enables already in place. The write strobe is then pulled low for a set number of clocks. It is released first, so that the strobe alone ends the memory's write cycle. The address and the byte enables are held for one further clock before the bus is freed. A read enables the chip and the output drivers, waits for a set access time and samples the bus. Between accesses the memory is parked in standby. The bidirectional data pins are split into an out bus, an in bus and a driver enable.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are 1. `mem_ce_p`, `mem_dq_oe` and `req_ack` are 0.
- R2: Whenever the low-active chip select is high, the block is in standby. The high-active select is low, both byte enables are high, the output enable is high, the write strobe is high and the data driver is off.
- R3: Before the write strobe falls, the chip selects, the address and the byte enables are asserted with the strobe high for exactly SETUP_CYC clocks.
- R4: In a write, the strobe is low for exactly PULSE_CYC consecutive clocks. Mask bit 1 selects the upper byte (`mem_ub_n` low) and mask bit 0 selects the lower byte (`mem_lb_n` low). The write word is driven with `mem_dq_oe` high.
- R5: In the clock after the write strobe rises, the chip selects, the address, the byte enables and the driven data are unchanged.
- R6: The output enable stays high for the whole of every write. The data driver is never on while the output enable is low.
- R7: A read holds the write strobe high, the output enable low and both byte enables low for exactly ACCESS_CYC clocks. `rsp_rdata` carries the word the memory presents, valid in the acknowledge cycle.
- R8: Every request gets exactly one acknowledge, lasting one clock.
- R9: A write request with mask 2'b00 is acknowledged without the write strobe ever going low. The stored word is left unchanged.
- R10: Between two accesses, even when the next request is presented in the acknowledge cycle, at least GAP_CYC standby clocks pass with the driver off and the output enable high.
- R11: A byte write changes only the selected byte. The other byte of the stored word keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Lane mask: bit 1 upper byte, bit 0 lower byte |
| req_ack | output | 1 | One-clock acknowledge |
| rsp_rdata | output | 16 | Read word |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce_p | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The hardest case to reach is a direction change with no slack: a read is presented in the very clock that acknowledges a write. Only then can the standby gap be too short. The bench drives the next request at the acknowledge sample, without waiting a cycle. A monitor measures the length of each standby run between chip-select assertions. Partial-lane merges are checked through a behavioural memory model that stores only enabled lanes on the strobe's rising edge, followed by full-word readback.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the static RAM access sequencer.
// Assumes: one encoding of sequencing phases, used by the FSM and the pin decoder.
package sram_ctrl_pkg;

    // Sequencing phases of one memory access
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RACCESS = 3'd4,
        ST_GAP     = 3'd5
    } seq_state_t;

    // Memory control pin bundle
    typedef struct packed {
        logic ce_n;
        logic ce_p;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_STANDBY = '{ce_n: 1'b1, ce_p: 1'b0, we_n: 1'b1,
                                          oe_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1,
                                          dq_oe: 1'b0};

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one sequencing phase.
// Assumes: load is pulsed on phase entry with (length - 1); done is high while the count is zero.
module sram_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stop there
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: accepts a host request, walks the write or read phases,
// captures read data and issues a one-clock acknowledge.
// Assumes: all phase lengths are at least 1; the host holds its request until acknowledged.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 16,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int ACCESS_CYC = 3,
    parameter int GAP_CYC    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    input  logic [DW-1:0] dq_in,
    output seq_state_t    state,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_wdata,
    output logic [1:0]    lat_mask,
    output logic [DW-1:0] rdata,
    output logic          ack
);

    localparam int MAXC = (SETUP_CYC > PULSE_CYC)
                        ? ((SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC)
                        : ((PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC);
    localparam int MAXL = (MAXC > GAP_CYC) ? MAXC : GAP_CYC;
    localparam int CW   = $clog2(MAXL + 1);

    seq_state_t    state_q, state_nxt;
    logic          t_load, t_done;
    logic [CW-1:0] t_val;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // Phase transition rules
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:
                if (req_valid) begin
                    if (!req_write)            state_nxt = ST_RACCESS;
                    else if (req_mask == 2'b00) state_nxt = ST_GAP;
                    else                       state_nxt = ST_WSETUP;
                end
            ST_WSETUP:  if (t_done) state_nxt = ST_WPULSE;
            ST_WPULSE:  if (t_done) state_nxt = ST_WHOLD;
            ST_WHOLD:   state_nxt = ST_GAP;
            ST_RACCESS: if (t_done) state_nxt = ST_GAP;
            ST_GAP:     if (t_done) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // Phase length loaded into the timer on entry
    always_comb begin
        t_load = (state_nxt != state_q);
        unique case (state_nxt)
            ST_WSETUP:  t_val = CW'(SETUP_CYC - 1);
            ST_WPULSE:  t_val = CW'(PULSE_CYC - 1);
            ST_RACCESS: t_val = CW'(ACCESS_CYC - 1);
            ST_GAP:     t_val = CW'(GAP_CYC - 1);
            default:    t_val = '0;
        endcase
    end

    // Phase register and one-clock acknowledge on entry to the gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack     <= 1'b0;
        end else begin
            state_q <= state_nxt;
            ack     <= (state_nxt == ST_GAP) && (state_q != ST_GAP);
        end
    end

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_mask  <= 2'b00;
        end else if (state_q == ST_IDLE && req_valid) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_mask  <= req_mask;
        end
    end

    // Read data sampled at the end of the access time
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (state_q == ST_RACCESS && t_done)
            rdata <= dq_in;
    end

    assign state = state_q;

endmodule

// File: rtl/sram_pin_decode.sv
// Maps the registered phase and latched lane mask onto the memory control pins.
// Assumes: the phase comes straight from a register, so each pin changes once per clock.
module sram_pin_decode
    import sram_ctrl_pkg::*;
(
    input  seq_state_t state,
    input  logic [1:0] lat_mask,
    output pin_ctl_t   pins
);

    // Pin levels for each phase
    always_comb begin
        pins = PINS_STANDBY;
        unique case (state)
            ST_WSETUP, ST_WPULSE, ST_WHOLD: begin
                pins.ce_n  = 1'b0;
                pins.ce_p  = 1'b1;
                pins.we_n  = (state != ST_WPULSE);
                pins.oe_n  = 1'b1;
                pins.ub_n  = ~lat_mask[1];
                pins.lb_n  = ~lat_mask[0];
                pins.dq_oe = 1'b1;
            end
            ST_RACCESS: begin
                pins.ce_n  = 1'b0;
                pins.ce_p  = 1'b1;
                pins.we_n  = 1'b1;
                pins.oe_n  = 1'b0;
                pins.ub_n  = 1'b0;
                pins.lb_n  = 1'b0;
                pins.dq_oe = 1'b0;
            end
            default: pins = PINS_STANDBY;
        endcase
    end

endmodule

// File: rtl/sram_byte_ctrl.sv
// Top level: host request port to 16-bit asynchronous static RAM with byte enables.
// Assumes: phase lengths in clocks cover the memory's setup, pulse, access and turnaround times.
module sram_byte_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW         = 19,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int ACCESS_CYC = 3,
    parameter int GAP_CYC    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_mask,
    output logic          req_ack,
    output logic [15:0]   rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_ce_p,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic [15:0]   mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [15:0]   mem_dq_in
);

    localparam int DW = 16;

    seq_state_t    state;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic [1:0]    lat_mask;
    pin_ctl_t      pins;

    sram_seq_fsm #(
        .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .ACCESS_CYC(ACCESS_CYC), .GAP_CYC(GAP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .dq_in     (mem_dq_in),
        .state     (state),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_mask  (lat_mask),
        .rdata     (rsp_rdata),
        .ack       (req_ack)
    );

    sram_pin_decode u_pins (
        .state    (state),
        .lat_mask (lat_mask),
        .pins     (pins)
    );

    assign mem_addr   = lat_addr;
    assign mem_dq_out = lat_wdata;
    assign mem_ce_n   = pins.ce_n;
    assign mem_ce_p   = pins.ce_p;
    assign mem_we_n   = pins.we_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_ub_n   = pins.ub_n;
    assign mem_lb_n   = pins.lb_n;
    assign mem_dq_oe  = pins.dq_oe;

endmodule

// File: rtl/sram_byte_ctrl_chk.sv
// Protocol checker for the memory pins, bound into sram_byte_ctrl.
// Assumes: synchronous active-low reset; all checks are disabled while it is held.
module sram_byte_ctrl_chk #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ack,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_ce_p,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_ub_n,
    input logic          mem_lb_n,
    input logic          mem_dq_oe
);

    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (!mem_ce_p && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

    assert_select_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_ce_n && mem_ce_p && !(mem_ub_n && mem_lb_n)));

    assert_strobe_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce_p && mem_dq_oe && !(mem_ub_n && mem_lb_n)));

    assert_hold_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)
                             && !mem_ce_n && mem_ce_p && mem_dq_oe));

    assert_no_drive_while_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

    assert_single_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_ack_in_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (mem_ce_n && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ack   (req_ack),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce_p  (mem_ce_p),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_byte_ctrl_tb.sv
module sram_byte_ctrl_tb;

    localparam int AW     = 19;
    localparam int SETUP  = 2;
    localparam int PULSE  = 3;
    localparam int ACCESS = 2;
    localparam int GAP    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = 2'b00;
    logic          req_ack;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_ce_p, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0]   mem_dq_out;
    logic [15:0]   mem_dq_in;

    int n_checks = 0;
    int n_errs   = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    sram_byte_ctrl #(
        .AW(AW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .ACCESS_CYC(ACCESS), .GAP_CYC(GAP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce_p(mem_ce_p), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory: stores enabled lanes when the strobe rises
    logic [15:0] model_mem [0:255];
    logic [15:0] exp_mem   [0:255];

    always @(posedge mem_we_n) begin
        if (rst_n === 1'b1 && mem_ce_n === 1'b0 && mem_ce_p === 1'b1) begin
            if (!mem_ub_n) model_mem[mem_addr[7:0]][15:8] = mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
            if (!mem_lb_n) model_mem[mem_addr[7:0]][7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
        end
    end

    always_comb begin
        if (!mem_ce_n && mem_ce_p && mem_we_n && !mem_oe_n)
            mem_dq_in = {mem_ub_n ? 8'h00 : model_mem[mem_addr[7:0]][15:8],
                         mem_lb_n ? 8'h00 : model_mem[mem_addr[7:0]][7:0]};
        else
            mem_dq_in = 16'h0000;
    end

    // Standby monitor: run length of chip-select-off clocks, and pin sanity there
    int run = 0;
    int last_run = 0;
    int viol_r2 = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_ce_n) begin
                run++;
                if (mem_ce_p || !mem_we_n || !mem_oe_n || !mem_ub_n || !mem_lb_n || mem_dq_oe)
                    viol_r2++;
            end else if (run != 0) begin
                last_run = run;
                run = 0;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_errs++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Per-request observations
    int s_setup, s_welow, s_oelow, s_acks, s_bad_lane, s_oe_in_wr, s_hold_ok, s_extra_ack, s_bad_addr;
    logic [15:0] s_rd;

    task automatic do_req(input bit wr, input logic [7:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit nowait);
        logic prev_we;
        logic prev_ub, prev_lb;
        logic [AW-1:0] prev_addr;
        bit seen_we;
        s_setup = 0; s_welow = 0; s_oelow = 0; s_acks = 0; s_bad_lane = 0;
        s_oe_in_wr = 0; s_hold_ok = 0; s_extra_ack = 0; s_bad_addr = 0; s_rd = '0;
        prev_we = 1'b1; prev_ub = 1'b1; prev_lb = 1'b1; prev_addr = '0; seen_we = 0;
        if (!nowait) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!mem_ce_n && mem_addr !== AW'(a)) s_bad_addr++;
            if (!mem_ce_n && mem_ce_p && mem_we_n && mem_oe_n && !seen_we) s_setup++;
            if (!mem_we_n) begin
                s_welow++;
                seen_we = 1;
                if ({mem_ub_n, mem_lb_n} !== ~m) s_bad_lane++;
                if (!mem_dq_oe || mem_dq_out !== d) s_bad_lane++;
            end
            if (!prev_we && mem_we_n) begin
                if (!mem_ce_n && mem_ce_p && mem_addr === prev_addr && mem_ub_n === prev_ub
                    && mem_lb_n === prev_lb && mem_dq_oe && mem_dq_out === d)
                    s_hold_ok++;
            end
            if (!mem_oe_n) s_oelow++;
            if (!mem_oe_n && (seen_we || mem_dq_oe)) s_oe_in_wr++;
            prev_we = mem_we_n; prev_ub = mem_ub_n; prev_lb = mem_lb_n; prev_addr = mem_addr;
            if (req_ack) begin
                s_acks++;
                s_rd = rsp_rdata;
                req_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic ack_once(input string req);
        @(negedge clk);
        chk(!req_ack, req, "ack lasts one clock", 32'(req_ack), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_ce_p, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ack}
            === 8'b10111100, "R1", "pins in reset",
            32'({mem_ce_n, mem_ce_p, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ack}),
            32'h0BC);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mem_ce_n, mem_ce_p, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ack}
            === 8'b10111100, "R1", "pins after reset",
            32'({mem_ce_n, mem_ce_p, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ack}),
            32'h0BC);
    endtask

    task automatic t_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] m);
        do_req(1'b1, a, d, m, 1'b0);
        chk(s_acks == 1, "R8", "write acknowledged", 32'(s_acks), 1);
        chk(s_setup == SETUP, "R3", "setup clocks", 32'(s_setup), SETUP);
        chk(s_welow == PULSE, "R4", "strobe low clocks", 32'(s_welow), PULSE);
        chk(s_bad_lane == 0, "R4", "lane enables and data", 32'(s_bad_lane), 0);
        chk(s_hold_ok == 1, "R5", "hold after strobe", 32'(s_hold_ok), 1);
        chk(s_oelow == 0 && s_oe_in_wr == 0, "R6", "output enable in write", 32'(s_oelow), 0);
        chk(s_bad_addr == 0, "R3", "address during write", 32'(s_bad_addr), 0);
        if (m[1]) exp_mem[a][15:8] = d[15:8];
        if (m[0]) exp_mem[a][7:0]  = d[7:0];
        ack_once("R8");
    endtask

    task automatic t_read(input logic [7:0] a, input string req);
        do_req(1'b0, a, 16'h0, 2'b11, 1'b0);
        chk(s_acks == 1, "R8", "read acknowledged", 32'(s_acks), 1);
        chk(s_oelow == ACCESS, "R7", "output enable clocks", 32'(s_oelow), ACCESS);
        chk(s_welow == 0 && s_oe_in_wr == 0, "R6", "no drive in read", 32'(s_oe_in_wr), 0);
        chk(s_rd === exp_mem[a], req, "read word", 32'(s_rd), 32'(exp_mem[a]));
        ack_once("R8");
    endtask

    task automatic t_noop(input logic [7:0] a);
        do_req(1'b1, a, 16'hFFFF, 2'b00, 1'b0);
        chk(s_acks == 1, "R9", "empty mask acknowledged", 32'(s_acks), 1);
        chk(s_welow == 0, "R9", "strobe never low", 32'(s_welow), 0);
        ack_once("R9");
        t_read(a, "R9");
    endtask

    task automatic t_b2b(input logic [7:0] a, input logic [15:0] d);
        do_req(1'b1, a, d, 2'b11, 1'b0);
        exp_mem[a] = d;
        chk(s_acks == 1, "R10", "first access acknowledged", 32'(s_acks), 1);
        do_req(1'b0, a, 16'h0, 2'b11, 1'b1);
        chk(last_run >= GAP, "R10", "standby gap clocks", 32'(last_run), GAP);
        chk(s_rd === d, "R10", "read after immediate turnaround", 32'(s_rd), 32'(d));
        ack_once("R8");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 16'h0000;
            exp_mem[i]   = 16'h0000;
        end
        t_reset();
        t_write(8'h10, 16'hA5C3, 2'b11);
        t_read(8'h10, "R7");
        t_write(8'h10, 16'h1234, 2'b01);
        t_read(8'h10, "R11");
        t_write(8'h10, 16'hBEEF, 2'b10);
        t_read(8'h10, "R11");
        t_read(8'h30, "R7");
        t_noop(8'h10);
        t_b2b(8'h20, 16'h5A5A);
        t_write(8'h41, 16'h00FF, 2'b11);
        t_read(8'h41, "R7");
        repeat (4) @(negedge clk);
        chk(viol_r2 == 0, "R2", "standby pin levels", 32'(viol_r2), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule